// File: doc/BRIEF.md
# Boosted Shallow Decision-Tree Seizure Classifier

This block turns per-channel neural features into a seizure or no-seizure verdict using a boosted ensemble of shallow binary decision trees. Each tree holds a small complete binary tree of nodes. Every internal node compares one requested feature value against an 8-bit threshold, and every leaf holds a signed 8-bit score. A tree walks from its root one level per comparison. At each level it asks its own feature port for exactly one (feature kind, channel) pair and raises the enable of that channel alone, so the rest of the recording array can stay powered down. It then waits for the answer before it fetches the next node.

The ensemble verdict is refreshed only on an epoch tick. At each tick the block adds up the most recent completed leaf score of every tree, using 0 for a tree that has not yet produced a result since it was enabled. It compares this sum with a programmable signed offset. A tree that is still descending when the tick arrives does not hold up the verdict. It finishes later and its score counts from the next tick on. Tree parameters are loaded through a write port while the classifier is disabled.

Top module: `dt_boost_classifier`

## Requirements
- R1: After reset `seizure`, `decision_sum`, `feat_req` and `chan_en` are all zero.
- R2: A node word is written to tree `wr_tree`, node `wr_node` only when `wr_en` is high and `run_en` is low. A write while `run_en` is high has no effect. The word layout is: bits 15:14 feature kind, bits 13:9 channel, bits 8:1 threshold (or signed leaf score), bit 0 leaf flag.
- R3: While a tree's `feat_req` is high, exactly one bit of its 32-bit `chan_en` slice is set, namely the bit at the requested channel index. While `feat_req` is low the slice is zero.
- R4: A tree holds `feat_req` high, with stable `feat_kind` and `feat_chan`, until `feat_ack` is sampled high. It then drops `feat_req` for at least one cycle.
- R5: Node n has its children at 2n+1 (left) and 2n+2 (right). The path goes right when the unsigned 8-bit `feat_val` is strictly greater than the node threshold. It goes left otherwise, so a value equal to the threshold goes left.
- R6: A node is a leaf when its leaf flag is set or when it lies at level 3 (nodes 7 to 14). Reaching a leaf records its signed score and marks the tree valid, and the leaf issues no feature request. A root that is a leaf yields a result with no request at all.
- R7: On an epoch tick, every tree that is idle or finished restarts at the root. A tree's first request for a node is raised two clock edges after the edge that started or advanced it, and a tree still descending continues undisturbed.
- R8: On the edge where `epoch_tick` is sampled high, `decision_sum` takes the signed sum of the last recorded score of every valid tree, with invalid trees contributing 0. It holds that value until the next tick. Scores recorded on the tick edge itself count from the next tick.
- R9: `seizure` is registered together with `decision_sum` and is set when the sum is strictly greater than the signed `score_ofs`.
- R10: While `run_en` is low, all trees are idle with no requests, valid bits are cleared, ticks are ignored, and `seizure` and `decision_sum` read zero from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Classifier enable; parameter writes allowed only while low |
| epoch_tick | input | 1 | One-cycle pulse that refreshes the verdict and restarts finished trees |
| wr_en | input | 1 | Parameter write strobe |
| wr_tree | input | 3 | Tree index of the write |
| wr_node | input | 4 | Node index of the write (0 to 14) |
| wr_data | input | 16 | Node word |
| score_ofs | input | 11 | Signed decision offset |
| feat_req | output | 8 | Per-tree feature request |
| feat_kind | output | 16 | Per-tree 2-bit feature kind |
| feat_chan | output | 40 | Per-tree 5-bit channel index |
| chan_en | output | 256 | Per-tree 32-bit one-hot channel enable |
| feat_ack | input | 8 | Per-tree feature answer strobe |
| feat_val | input | 64 | Per-tree 8-bit unsigned feature value |
| seizure | output | 1 | Registered verdict |
| decision_sum | output | 11 | Registered signed ensemble sum |

## Verification
The checker watches, on every cycle and for every tree, the request handshake: the one-hot channel enable while a request is raised, a request that holds its selector steady until answered, and the drop after each answer. It also checks that the verdict never moves between ticks while enabled and that everything is quiet while disabled. The branch direction at the equality boundary, the leaf scores and the root-leaf case can only be shown by the bench's scenarios, as can late trees carrying results across ticks, the strict offset comparison and the blocking of writes while enabled. The reference model predicts these cycle by cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int KIND_W = 2;
  localparam int CHANS  = 32;
  localparam int CHAN_W = $clog2(CHANS);
  localparam int THR_W  = 8;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [CHAN_W-1:0] chan;
    logic [THR_W-1:0]  thr;
    logic              leaf;
  } node_t;

  localparam int NODE_W = $bits(node_t);

  typedef enum logic [2:0] {
    W_IDLE, W_FETCH, W_DECIDE, W_REQ, W_DONE
  } walk_st_t;
endpackage

// File: rtl/dt_node_mem.sv
module dt_node_mem #(
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(2**(DEPTH+1)-1)-1:0] waddr,
  input  dt_pkg::node_t            wdata,
  input  logic [$clog2(2**(DEPTH+1)-1)-1:0] raddr,
  output dt_pkg::node_t            rdata
);
  localparam int NODES = 2**(DEPTH+1) - 1;
  localparam int AW    = $clog2(NODES);

  dt_pkg::node_t mem [NODES];

  always_ff @(posedge clk) begin
    if (we && (waddr < AW'(NODES))) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dt_tree_walker.sv
module dt_tree_walker #(
  parameter int DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run_en,
  input  logic                        start,
  output logic [$clog2(2**(DEPTH+1)-1)-1:0] rd_addr,
  input  dt_pkg::node_t               rd_node,
  output logic                        req,
  output logic [dt_pkg::KIND_W-1:0]   kind,
  output logic [dt_pkg::CHAN_W-1:0]   chan,
  output logic [dt_pkg::CHANS-1:0]    chan_on,
  input  logic                        ack,
  input  logic [dt_pkg::THR_W-1:0]    val,
  output logic [dt_pkg::THR_W-1:0]    res_score,
  output logic                        res_valid
);
  import dt_pkg::*;
  localparam int NODES     = 2**(DEPTH+1) - 1;
  localparam int INT_NODES = 2**DEPTH - 1;
  localparam int AW        = $clog2(NODES);

  walk_st_t          st;
  logic [AW-1:0]     node;
  logic [KIND_W-1:0] cur_kind;
  logic [CHAN_W-1:0] cur_chan;
  logic [THR_W-1:0]  cur_thr;
  logic              at_leaf;

  assign at_leaf = rd_node.leaf || (node >= AW'(INT_NODES));

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      st        <= W_IDLE;
      node      <= '0;
      cur_kind  <= '0;
      cur_chan  <= '0;
      cur_thr   <= '0;
      res_score <= '0;
      res_valid <= 1'b0;
    end else begin
      case (st)
        W_IDLE, W_DONE: begin
          if (start) begin
            node <= '0;
            st   <= W_FETCH;
          end
        end
        W_FETCH: st <= W_DECIDE;
        W_DECIDE: begin
          cur_kind <= rd_node.kind;
          cur_chan <= rd_node.chan;
          cur_thr  <= rd_node.thr;
          if (at_leaf) begin
            res_score <= rd_node.thr;
            res_valid <= 1'b1;
            st        <= W_DONE;
          end else begin
            st <= W_REQ;
          end
        end
        W_REQ: begin
          if (ack) begin
            node <= {node[AW-2:0], 1'b0} + ((val > cur_thr) ? AW'(2) : AW'(1));
            st   <= W_FETCH;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign rd_addr = node;
  assign req     = (st == W_REQ);
  assign kind    = cur_kind;
  assign chan    = cur_chan;
  assign chan_on = req ? (CHANS'(1) << cur_chan) : '0;
endmodule

// File: rtl/dt_vote.sv
module dt_vote #(
  parameter int NTREES = 8,
  parameter int SUM_W  = 11
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             run_en,
  input  logic                             tick,
  input  logic [NTREES*dt_pkg::THR_W-1:0]  scores,
  input  logic [NTREES-1:0]                valid,
  input  logic signed [SUM_W-1:0]          ofs,
  output logic                             seizure,
  output logic signed [SUM_W-1:0]          sum_q
);
  localparam int SW = dt_pkg::THR_W;

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTREES; i++) begin
      logic signed [SW-1:0] s;
      s = scores[i*SW +: SW];
      if (valid[i]) acc = acc + SUM_W'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      sum_q   <= '0;
      seizure <= 1'b0;
    end else if (tick) begin
      sum_q   <= acc;
      seizure <= (acc > ofs);
    end
  end
endmodule

// File: rtl/dt_boost_classifier.sv
module dt_boost_classifier #(
  parameter int NTREES  = 8,
  parameter int DEPTH   = 3,
  parameter int SUM_W   = 11,
  localparam int NODES  = 2**(DEPTH+1) - 1,
  localparam int NAW    = $clog2(NODES),
  localparam int TAW    = $clog2(NTREES),
  localparam int KW     = dt_pkg::KIND_W,
  localparam int CW     = dt_pkg::CHAN_W,
  localparam int NCH    = dt_pkg::CHANS,
  localparam int TW     = dt_pkg::THR_W,
  localparam int NW     = dt_pkg::NODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_en,
  input  logic                    epoch_tick,
  input  logic                    wr_en,
  input  logic [TAW-1:0]          wr_tree,
  input  logic [NAW-1:0]          wr_node,
  input  logic [NW-1:0]           wr_data,
  input  logic signed [SUM_W-1:0] score_ofs,
  output logic [NTREES-1:0]       feat_req,
  output logic [NTREES*KW-1:0]    feat_kind,
  output logic [NTREES*CW-1:0]    feat_chan,
  output logic [NTREES*NCH-1:0]   chan_en,
  input  logic [NTREES-1:0]       feat_ack,
  input  logic [NTREES*TW-1:0]    feat_val,
  output logic                    seizure,
  output logic signed [SUM_W-1:0] decision_sum
);
  logic [NTREES*TW-1:0] scores;
  logic [NTREES-1:0]    valid;
  logic                 wr_ok;

  assign wr_ok = wr_en && !run_en;

  for (genvar t = 0; t < NTREES; t++) begin : g_tree
    logic [NAW-1:0] rd_addr;
    dt_pkg::node_t  rd_node;

    dt_node_mem #(.DEPTH(DEPTH)) mem_i (
      .clk   (clk),
      .we    (wr_ok && (wr_tree == TAW'(t))),
      .waddr (wr_node),
      .wdata (dt_pkg::node_t'(wr_data)),
      .raddr (rd_addr),
      .rdata (rd_node)
    );

    dt_tree_walker #(.DEPTH(DEPTH)) walk_i (
      .clk       (clk),
      .rst       (rst),
      .run_en    (run_en),
      .start     (epoch_tick),
      .rd_addr   (rd_addr),
      .rd_node   (rd_node),
      .req       (feat_req[t]),
      .kind      (feat_kind[t*KW +: KW]),
      .chan      (feat_chan[t*CW +: CW]),
      .chan_on   (chan_en[t*NCH +: NCH]),
      .ack       (feat_ack[t]),
      .val       (feat_val[t*TW +: TW]),
      .res_score (scores[t*TW +: TW]),
      .res_valid (valid[t])
    );
  end

  dt_vote #(.NTREES(NTREES), .SUM_W(SUM_W)) vote_i (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .tick    (epoch_tick),
    .scores  (scores),
    .valid   (valid),
    .ofs     (score_ofs),
    .seizure (seizure),
    .sum_q   (decision_sum)
  );
endmodule

// File: rtl/dt_boost_checker.sv
module dt_boost_checker #(
  parameter int NTREES = 8,
  parameter int SUM_W  = 11,
  localparam int KW    = dt_pkg::KIND_W,
  localparam int CW    = dt_pkg::CHAN_W,
  localparam int NCH   = dt_pkg::CHANS
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  run_en,
  input logic                  epoch_tick,
  input logic [NTREES-1:0]     feat_req,
  input logic [NTREES-1:0]     feat_ack,
  input logic [NTREES*KW-1:0]  feat_kind,
  input logic [NTREES*CW-1:0]  feat_chan,
  input logic [NTREES*NCH-1:0] chan_en,
  input logic                  seizure,
  input logic [SUM_W-1:0]      decision_sum
);
  for (genvar t = 0; t < NTREES; t++) begin : g_chk
    // R3: channel enable follows the request
    a_r3_chan_onehot: assert property (@(posedge clk) disable iff (rst)
      feat_req[t] ? ($countones(chan_en[t*NCH +: NCH]) == 1)
                  : (chan_en[t*NCH +: NCH] == '0));

    // R4: request held with steady selector until answered
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
      (feat_req[t] && !feat_ack[t] && run_en) |=>
        (feat_req[t] && $stable(feat_kind[t*KW +: KW]) && $stable(feat_chan[t*CW +: CW])));

    // R4: request drops after an answer
    a_r4_req_drop: assert property (@(posedge clk) disable iff (rst)
      (feat_req[t] && feat_ack[t]) |=> !feat_req[t]);
  end

  // R8: verdict stable between ticks
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (run_en && !epoch_tick) |=> ($stable(decision_sum) && $stable(seizure)));

  // R10: quiet while disabled
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (feat_req == '0 && !seizure && decision_sum == '0));
endmodule

bind dt_boost_classifier dt_boost_checker #(.NTREES(NTREES), .SUM_W(SUM_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .run_en       (run_en),
  .epoch_tick   (epoch_tick),
  .feat_req     (feat_req),
  .feat_ack     (feat_ack),
  .feat_kind    (feat_kind),
  .feat_chan    (feat_chan),
  .chan_en      (chan_en),
  .seizure      (seizure),
  .decision_sum (decision_sum)
);

// File: tb/dt_boost_classifier_tb_top.sv
`timescale 1ns/1ps
module dt_boost_classifier_tb_top;
  localparam int NT = 8;

  logic clk = 0;
  logic rst = 1;
  logic run_en = 0;
  logic epoch_tick = 0;
  logic wr_en = 0;
  logic [2:0] wr_tree = 0;
  logic [3:0] wr_node = 0;
  logic [15:0] wr_data = 0;
  logic signed [10:0] score_ofs = 0;
  logic [NT-1:0] feat_req;
  logic [NT*2-1:0] feat_kind;
  logic [NT*5-1:0] feat_chan;
  logic [NT*32-1:0] chan_en;
  logic [NT-1:0] feat_ack = 0;
  logic [NT*8-1:0] feat_val = 0;
  logic seizure;
  logic signed [10:0] decision_sum;

  always #5 clk = ~clk;

  dt_boost_classifier dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  int mm [NT][15];
  int ph [NT], nd [NT], rs [NT], dly [NT], cnt [NT], nreq [NT];
  bit vl [NT];
  int msum = 0;
  bit mdec = 0;
  int t2q [$];

  function automatic int fv(int k, int c);
    return (k*61 + c*23 + 17) % 256;
  endfunction

  function automatic int sx(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic int nword(int t, int n);
    int k, c, th, lf;
    if (n >= 7) begin
      th = (((t*29 + n*11) % 200) - 100) & 255;
      return (th << 1) | 1;
    end
    k = (t + n) % 4; c = (t*7 + n*5) % 32; th = (t*40 + n*53 + 30) % 256; lf = 0;
    if (t == 1 && n == 0) begin th = 55; lf = 1; end
    if (t == 2 && n == 0) th = fv(k, c);
    return (k << 14) | (c << 9) | (th << 1) | lf;
  endfunction

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++) begin ph[t] = 0; nd[t] = 0; rs[t] = 0; vl[t] = 0; end
      msum = 0; mdec = 0;
    end else begin
      if (!run_en) begin msum = 0; mdec = 0; end
      else if (epoch_tick) begin
        int s; s = 0;
        for (int t = 0; t < NT; t++) if (vl[t]) s += sx(rs[t]);
        msum = s; mdec = (s > score_ofs);
      end
      if (wr_en && !run_en && wr_node < 15) mm[wr_tree][wr_node] = wr_data;
      for (int t = 0; t < NT; t++) begin
        int w;
        w = mm[t][nd[t]];
        if (!run_en) begin ph[t] = 0; nd[t] = 0; vl[t] = 0; end
        else case (ph[t])
          0, 4: if (epoch_tick) begin ph[t] = 1; nd[t] = 0; end
          1: ph[t] = 2;
          2: if ((w & 1) || nd[t] >= 7) begin rs[t] = (w >> 1) & 255; vl[t] = 1; ph[t] = 4; end
             else ph[t] = 3;
          3: if (feat_ack[t]) begin
               nd[t] = (fv((w >> 14) & 3, (w >> 9) & 31) > ((w >> 1) & 255)) ? 2*nd[t] + 2 : 2*nd[t] + 1;
               ph[t] = 1;
             end
          default: ph[t] = 0;
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      logic [NT-1:0] er;
      logic [NT*32-1:0] ece;
      logic [NT*7-1:0] esel, asel;
      er = 0; ece = 0; esel = 0; asel = 0;
      for (int t = 0; t < NT; t++) begin
        int w;
        w = mm[t][nd[t]];
        if (ph[t] == 3) begin
          er[t] = 1;
          ece[t*32 + ((w >> 9) & 31)] = 1;
          esel[t*7 +: 7] = 7'(((w >> 14) & 3) * 32 + ((w >> 9) & 31));
          asel[t*7 +: 7] = {feat_kind[t*2 +: 2], feat_chan[t*5 +: 5]};
        end
      end
      chk(feat_req == er, "R7 request timing", 256'(feat_req), 256'(er));
      chk(chan_en == ece, "R3 channel enable", chan_en, ece);
      chk(asel == esel, "R5 requested node kind/channel", 256'(asel), 256'(esel));
      chk(decision_sum == 11'(msum), "R8 ensemble sum", 256'(decision_sum), 256'(11'(msum)));
      chk(seizure == mdec, "R9 seizure flag", 256'(seizure), 256'(mdec));
    end
  end

  // feature unit responder
  always @(negedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (feat_ack[t]) feat_ack[t] = 0;
      else if (feat_req[t]) begin
        if (cnt[t] >= dly[t]) begin
          feat_ack[t] = 1;
          feat_val[t*8 +: 8] = 8'(fv(int'(feat_kind[t*2 +: 2]), int'(feat_chan[t*5 +: 5])));
          cnt[t] = 0;
          nreq[t]++;
          if (t == 2) t2q.push_back(int'(feat_chan[t*5 +: 5]));
        end else cnt[t]++;
      end else cnt[t] = 0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int t, int n, int d);
    @(negedge clk);
    wr_en = 1; wr_tree = 3'(t); wr_node = 4'(n); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic epoch(int period);
    repeat (period - 1) @(negedge clk);
    epoch_tick = 1;
    @(negedge clk);
    epoch_tick = 0;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin dly[t] = 1; cnt[t] = 0; nreq[t] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(seizure == 0 && decision_sum == 0, "R1 reset verdict", 256'(decision_sum), 0);
    chk(feat_req == 0 && chan_en == 0, "R1 reset requests", 256'(feat_req), 0);

    for (int t = 0; t < NT; t++)
      for (int n = 0; n < 15; n++) wr(t, n, nword(t, n));

    run_en = 1;
    wr(0, 0, (8'd77 << 1) | 1);
    for (int e = 0; e < 3; e++) epoch(40);
    chk(nreq[0] > 0, "R2 write ignored while enabled", 256'(nreq[0]), 1);
    chk(nreq[1] == 0, "R6 root leaf issues no request", 256'(nreq[1]), 0);
    chk(t2q.size() > 1 && t2q[1] == 19, "R5 equal value goes left", 256'(t2q.size() > 1 ? t2q[1] : -1), 19);
    chk(decision_sum == 11'(msum) && msum != 0, "R6 leaf scores summed", 256'(decision_sum), 256'(11'(msum)));

    score_ofs = 11'(msum);
    epoch(40);
    chk(seizure == 0, "R9 sum equal to offset is not a seizure", 256'(seizure), 0);
    score_ofs = 11'(msum - 1);
    epoch(40);
    chk(seizure == 1, "R9 sum above offset is a seizure", 256'(seizure), 1);
    score_ofs = -11'sd1000;

    dly[5] = 20;
    for (int e = 0; e < 5; e++) epoch(40);
    dly[5] = 1;
    for (int e = 0; e < 2; e++) epoch(30);

    @(negedge clk);
    run_en = 0;
    @(negedge clk);
    chk(feat_req == 0 && seizure == 0 && decision_sum == 0, "R10 disabled outputs", 256'(decision_sum), 0);
    epoch(5);
    chk(decision_sum == 0, "R10 tick ignored while disabled", 256'(decision_sum), 0);
    for (int n = 7; n < 15; n++) wr(3, n, ((8'(n * 9)) << 1) | 1);
    run_en = 1;
    epoch(20);
    chk(decision_sum == 0, "R8 invalid trees contribute zero", 256'(decision_sum), 0);
    for (int e = 0; e < 3; e++) epoch(40);
    repeat (5) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule